// File: doc/BRIEF.md
# Priority-Level Interrupt Arbiter with Mask

This block chooses which of many interrupt requests reaches the processor. Every peripheral source carries a 4-bit priority level. Software programs these levels through a small register bus. Two debug sources are fixed at the top level, 15:
- a hardware breakpoint unit;
- a serial debug port.

Each debug source is caught on a rising edge and latched until the processor takes it. A request is passed on only if its level is strictly above the 4-bit mask that the block holds for the processor's status register.

The arbiter registers its result once per clock: a request flag, the winning source, its level and a vector unique to that source. When the processor acknowledges, the mask takes the accepted level and the edge latch of an accepted debug source clears. The processor can also load the mask directly through a separate write port, for example when it returns from a handler.

Top module: `irq_level_arb`

## Requirements
- R1: After reset, irq_req is 0, irq_src, irq_lvl and irq_vec are 0, mask_lvl is 15 and every priority field reads back 0.
- R2: Bus address k holds the levels of sources 4k to 4k+3, with source 4k+j at bits 4j+3:4j. bus_rd_data follows bus_rd_addr in the same cycle. Writes to an address with no sources, or to nibbles with no source behind them, are ignored, and those bits read 0.
- R3: A source is forwarded only when its level is strictly greater than mask_lvl, so a source at level 0 never raises irq_req.
- R4: Among eligible sources the highest level wins. On a tie, debug sources rank above peripherals, the breakpoint ranks above serial debug, and among peripherals the lowest index wins.
- R5: irq_req, irq_src, irq_lvl and irq_vec reflect the inputs and the mask sampled at the previous rising clock edge.
- R6: Source codes are: peripheral i is i, the breakpoint is NUM_SRC and serial debug is NUM_SRC+1. Vectors are: peripheral i gives VEC_BASE+i, the breakpoint gives BRK_VEC and serial debug gives DBG_VEC.
- R7: A debug source has level 15. It becomes pending on a rising edge of its input and stays pending until accepted. An input held high raises it only once.
- R8: irq_ack while irq_req is 1 has these effects at the next edge:
  - mask_lvl is loaded with irq_lvl;
  - irq_req is 0 for one cycle;
  - the pending latch of an accepted debug source is cleared.

  irq_ack while irq_req is 0 is ignored.
- R9: mask_wr_en loads mask_lvl from mask_wr_lvl at the next edge. A same-cycle acceptance takes precedence.
- R10: While irq_req is 0, irq_src, irq_lvl and irq_vec are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_req | input | NUM_SRC | Level requests from peripheral sources |
| brk_in | input | 1 | Breakpoint request, rising-edge detected |
| sdbg_in | input | 1 | Serial debug request, rising-edge detected |
| bus_wr_en | input | 1 | Priority register write strobe |
| bus_wr_addr | input | ADDR_W | Priority register write address |
| bus_wr_data | input | 16 | Priority register write data |
| bus_rd_addr | input | ADDR_W | Priority register read address |
| bus_rd_data | output | 16 | Priority register read data (combinational) |
| mask_wr_en | input | 1 | Direct mask load strobe |
| mask_wr_lvl | input | 4 | Mask value to load |
| irq_ack | input | 1 | Processor accepts the presented request |
| irq_req | output | 1 | Request to the processor |
| irq_src | output | SRC_W | Winning source code |
| irq_lvl | output | 4 | Winning level |
| irq_vec | output | VEC_W | Vector of the winning source |
| mask_lvl | output | 4 | Current mask level |

## Verification
Request outputs are due one rising edge after the requests and the mask are sampled. A debug input's rising edge appears after that same single edge, because the fresh edge joins arbitration directly. Mask changes caused by an acknowledge or a direct load, and the one-cycle drop of irq_req, appear after the next edge. Priority writes take effect at the next edge, so they influence arbitration one edge later still. Read data is valid in the cycle of the address.

The bench drives every input on the falling edge and advances its reference model once per rising edge. It compares all outputs at the next falling edge, so each result is sampled exactly in the cycle it becomes due. Directed sequences count edges explicitly around debug edges, acknowledges and mask loads.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W        = 4;
    localparam int SLOT_PER_REG = 4;
    localparam int BUS_W        = LVL_W * SLOT_PER_REG;
    localparam int NUM_DBG      = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_MAX = '1;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int ADDR_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [BUS_W-1:0]      rd_data,
    output lvl_t [NUM_SRC-1:0]    prio_o
);
    localparam int NUM_REG = (NUM_SRC + SLOT_PER_REG - 1) / SLOT_PER_REG;
    localparam int SLOTS   = NUM_REG * SLOT_PER_REG;

    lvl_t [SLOTS-1:0] slot_d, slot_q;

    // next-state: a write lands only on slots backed by a real source
    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            for (int r = 0; r < NUM_REG; r++) begin
                if (wr_addr == ADDR_W'(r)) begin
                    for (int j = 0; j < SLOT_PER_REG; j++) begin
                        if (r * SLOT_PER_REG + j < NUM_SRC) begin
                            slot_d[r*SLOT_PER_REG+j] = wr_data[j*LVL_W +: LVL_W];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REG; r++) begin
            if (rd_addr == ADDR_W'(r)) begin
                for (int j = 0; j < SLOT_PER_REG; j++) begin
                    rd_data[j*LVL_W +: LVL_W] = slot_q[r*SLOT_PER_REG+j];
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        assign prio_o[i] = slot_q[i];
    end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic clr_i,
    output logic cand_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        rise       = sig_i & ~st_q.prev;
        st_d.prev  = sig_i;
        st_d.pend  = (st_q.pend & ~clr_i) | rise;
        cand_o     = st_q.pend | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int SRC_W   = 4
) (
    input  lvl_t [NUM_SRC-1:0]     prio_i,
    input  logic [NUM_SRC-1:0]     req_i,
    input  logic [NUM_DBG-1:0]     dbg_i,
    input  lvl_t                   mask_i,
    output logic                   hit_o,
    output logic [SRC_W-1:0]       src_o,
    output lvl_t                   lvl_o
);
    lvl_t best;

    // the bar starts at the mask, so only strictly higher levels qualify;
    // strict compare keeps the earlier candidate on a tie
    always_comb begin
        hit_o = 1'b0;
        best  = mask_i;
        src_o = '0;
        for (int d = 0; d < NUM_DBG; d++) begin
            if (dbg_i[d] && (LVL_MAX > best)) begin
                hit_o = 1'b1;
                best  = LVL_MAX;
                src_o = SRC_W'(NUM_SRC + d);
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (prio_i[i] > best)) begin
                hit_o = 1'b1;
                best  = prio_i[i];
                src_o = SRC_W'(i);
            end
        end
        lvl_o = hit_o ? best : '0;
    end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC  = 10,
    parameter int ADDR_W   = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int BRK_VEC  = 11,
    parameter int DBG_VEC  = 12,
    localparam int SRC_W   = $clog2(NUM_SRC + NUM_DBG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   periph_req,
    input  logic                 brk_in,
    input  logic                 sdbg_in,
    input  logic                 bus_wr_en,
    input  logic [ADDR_W-1:0]    bus_wr_addr,
    input  logic [15:0]          bus_wr_data,
    input  logic [ADDR_W-1:0]    bus_rd_addr,
    output logic [15:0]          bus_rd_data,
    input  logic                 mask_wr_en,
    input  logic [3:0]           mask_wr_lvl,
    input  logic                 irq_ack,
    output logic                 irq_req,
    output logic [SRC_W-1:0]     irq_src,
    output logic [3:0]           irq_lvl,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [3:0]           mask_lvl
);
    localparam int SRC_BRK = NUM_SRC;
    localparam int SRC_DBG = NUM_SRC + 1;

    typedef struct packed {
        logic              req;
        logic [SRC_W-1:0]  src;
        lvl_t              lvl;
        logic [VEC_W-1:0]  vec;
        lvl_t              mask;
    } arb_st_t;

    arb_st_t st_d, st_q;

    lvl_t [NUM_SRC-1:0]  prio;
    logic [NUM_DBG-1:0]  dbg_in;
    logic [NUM_DBG-1:0]  dbg_cand;
    logic [NUM_DBG-1:0]  dbg_clr;
    logic                accept;
    logic                hit;
    logic [SRC_W-1:0]    win_src;
    lvl_t                win_lvl;

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] s);
        if (s == SRC_W'(SRC_BRK))      return VEC_W'(BRK_VEC);
        else if (s == SRC_W'(SRC_DBG)) return VEC_W'(DBG_VEC);
        else                           return VEC_W'(VEC_BASE) + VEC_W'(s);
    endfunction

    irq_prio_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_addr (bus_wr_addr),
        .wr_data (bus_wr_data),
        .rd_addr (bus_rd_addr),
        .rd_data (bus_rd_data),
        .prio_o  (prio)
    );

    assign dbg_in = {sdbg_in, brk_in};
    assign accept = irq_ack & st_q.req;

    always_comb begin
        for (int d = 0; d < NUM_DBG; d++) begin
            dbg_clr[d] = accept && (st_q.src == SRC_W'(NUM_SRC + d));
        end
    end

    for (genvar d = 0; d < NUM_DBG; d++) begin : g_dbg
        irq_edge_latch u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (dbg_in[d]),
            .clr_i  (dbg_clr[d]),
            .cand_o (dbg_cand[d])
        );
    end

    irq_pick #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_pick (
        .prio_i  (prio),
        .req_i   (periph_req),
        .dbg_i   (dbg_cand),
        .mask_i  (st_q.mask),
        .hit_o   (hit),
        .src_o   (win_src),
        .lvl_o   (win_lvl)
    );

    always_comb begin
        st_d = st_q;
        // an accepting cycle blanks the next result so the taken source is not re-shown
        st_d.req = hit & ~accept;
        st_d.src = st_d.req ? win_src         : '0;
        st_d.lvl = st_d.req ? win_lvl         : '0;
        st_d.vec = st_d.req ? vec_of(win_src) : '0;
        if (accept)          st_d.mask = st_q.lvl;
        else if (mask_wr_en) st_d.mask = mask_wr_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= LVL_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req  = st_q.req;
    assign irq_src  = st_q.src;
    assign irq_lvl  = st_q.lvl;
    assign irq_vec  = st_q.vec;
    assign mask_lvl = st_q.mask;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
    parameter int NUM_SRC  = 10,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int SRC_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_ack,
    input logic             mask_wr_en,
    input logic [3:0]       mask_wr_lvl,
    input logic             irq_req,
    input logic [SRC_W-1:0] irq_src,
    input logic [3:0]       irq_lvl,
    input logic [VEC_W-1:0] irq_vec,
    input logic [3:0]       mask_lvl
);
    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_lvl > $past(mask_lvl)); // R3

    AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && irq_req |=> !irq_req && mask_lvl == $past(irq_lvl)); // R8

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !irq_req && !mask_wr_en |=> $stable(mask_lvl)); // R8

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en && !(irq_ack && irq_req) |=> mask_lvl == $past(mask_wr_lvl)); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_src == '0 && irq_lvl == '0 && irq_vec == '0); // R10

    AST_DEBUG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_src >= SRC_W'(NUM_SRC) |-> irq_lvl == 4'hF); // R7

    AST_PERIPH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_src < SRC_W'(NUM_SRC) |-> irq_vec == VEC_W'(VEC_BASE) + VEC_W'(irq_src)); // R6
endmodule

bind irq_level_arb irq_level_arb_chk #(
    .NUM_SRC  (NUM_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .SRC_W    (SRC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_ack     (irq_ack),
    .mask_wr_en  (mask_wr_en),
    .mask_wr_lvl (mask_wr_lvl),
    .irq_req     (irq_req),
    .irq_src     (irq_src),
    .irq_lvl     (irq_lvl),
    .irq_vec     (irq_vec),
    .mask_lvl    (mask_lvl)
);

// File: tb/test_irq_level_arb.sv
module test_irq_level_arb;
    localparam int N    = 10;
    localparam int BRK  = N;
    localparam int DBG  = N + 1;
    localparam int VB   = 64;
    localparam int BVEC = 11;
    localparam int DVEC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] periph_req = '0;
    logic        brk_in = 1'b0, sdbg_in = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_wr_addr = '0;
    logic [15:0] bus_wr_data = '0;
    logic [3:0]  bus_rd_addr = '0;
    logic [15:0] bus_rd_data;
    logic        mask_wr_en = 1'b0;
    logic [3:0]  mask_wr_lvl = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_src;
    logic [3:0]  irq_lvl;
    logic [7:0]  irq_vec;
    logic [3:0]  mask_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_prio [N];
    int m_mask, m_req, m_src, m_lvl, m_vec;
    int m_bprev, m_bpend, m_dprev, m_dpend;

    always #10 clk = ~clk;

    irq_level_arb i_irq_level_arb (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
        .brk_in(brk_in), .sdbg_in(sdbg_in),
        .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .mask_wr_en(mask_wr_en), .mask_wr_lvl(mask_wr_lvl), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_src(irq_src), .irq_lvl(irq_lvl),
        .irq_vec(irq_vec), .mask_lvl(mask_lvl)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic int rd_model(input int a);
        int v = 0;
        if (a < (N + 3) / 4) begin
            for (int j = 0; j < 4; j++) begin
                if (4 * a + j < N) v = v | (m_prio[4*a+j] << (4 * j));
            end
        end
        return v;
    endfunction

    function automatic int vec_model(input int s);
        if (s == BRK) return BVEC;
        if (s == DBG) return DVEC;
        return VB + s;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_prio[i] = 0;
        m_mask = 15; m_req = 0; m_src = 0; m_lvl = 0; m_vec = 0;
        m_bprev = 0; m_bpend = 0; m_dprev = 0; m_dpend = 0;
    endtask

    task automatic compare_all();
        string t3, t4, t6;
        t3 = m_req ? "R3" : "R10";
        t4 = m_req ? "R4" : "R10";
        t6 = m_req ? "R6" : "R10";
        check("R5", "irq_req", int'(irq_req), m_req);
        check(t4, "irq_src", int'(irq_src), m_src);
        check(t3, "irq_lvl", int'(irq_lvl), m_lvl);
        check(t6, "irq_vec", int'(irq_vec), m_vec);
        check("R8", "mask_lvl", int'(mask_lvl), m_mask);
        check("R2", "bus_rd_data", int'(bus_rd_data), rd_model(int'(bus_rd_addr)));
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic tick();
        int brise, drise, bc, dc, acc, found, ws, wl;
        int n_mask, n_bpend, n_dpend;
        int np [N];
        brise = (brk_in && !m_bprev) ? 1 : 0;
        drise = (sdbg_in && !m_dprev) ? 1 : 0;
        bc = (m_bpend || brise) ? 1 : 0;
        dc = (m_dpend || drise) ? 1 : 0;
        acc = (irq_ack && m_req) ? 1 : 0;
        found = 0; ws = 0; wl = 0;
        for (int lv = 15; lv > m_mask && !found; lv--) begin
            if (lv == 15 && bc) begin found = 1; ws = BRK; wl = 15; end
            else if (lv == 15 && dc) begin found = 1; ws = DBG; wl = 15; end
            else begin
                for (int i = 0; i < N && !found; i++) begin
                    if (periph_req[i] && m_prio[i] == lv) begin found = 1; ws = i; wl = lv; end
                end
            end
        end
        n_bpend = ((m_bpend && !(acc && m_src == BRK)) || brise) ? 1 : 0;
        n_dpend = ((m_dpend && !(acc && m_src == DBG)) || drise) ? 1 : 0;
        n_mask  = acc ? m_lvl : (mask_wr_en ? int'(mask_wr_lvl) : m_mask);
        for (int i = 0; i < N; i++) np[i] = m_prio[i];
        if (bus_wr_en && bus_wr_addr < (N + 3) / 4) begin
            for (int j = 0; j < 4; j++) begin
                if (4 * bus_wr_addr + j < N) np[4*bus_wr_addr+j] = (bus_wr_data >> (4 * j)) & 15;
            end
        end
        @(posedge clk);
        m_req = (found && !acc) ? 1 : 0;
        m_src = m_req ? ws : 0;
        m_lvl = m_req ? wl : 0;
        m_vec = m_req ? vec_model(ws) : 0;
        m_mask = n_mask;
        m_bpend = n_bpend; m_dpend = n_dpend;
        m_bprev = brk_in; m_dprev = sdbg_in;
        for (int i = 0; i < N; i++) m_prio[i] = np[i];
        @(negedge clk);
        compare_all();
        irq_ack = 1'b0; mask_wr_en = 1'b0; bus_wr_en = 1'b0;
    endtask

    task automatic bus_write(input int a, input int d);
        bus_wr_en = 1'b1; bus_wr_addr = 4'(a); bus_wr_data = 16'(d);
        tick();
    endtask

    task automatic set_mask(input int v);
        mask_wr_en = 1'b1; mask_wr_lvl = 4'(v);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "irq_req", int'(irq_req), 0);
        check("R1", "mask_lvl", int'(mask_lvl), 15);
        check("R1", "irq_vec", int'(irq_vec), 0);
        for (int a = 0; a < 3; a++) begin
            bus_rd_addr = 4'(a); #1;
            check("R1", "prio readback", int'(bus_rd_data), 0);
        end

        // R2: register packing and ignored slots
        bus_write(0, 16'h4321);
        bus_write(1, 16'h5D76);
        bus_write(2, 16'hFFAB);
        bus_write(3, 16'hFFFF);
        bus_rd_addr = 4'd2; #1;
        check("R2", "partial reg", int'(bus_rd_data), 16'h00AB);
        bus_rd_addr = 4'd3; #1;
        check("R2", "absent reg", int'(bus_rd_data), 0);
        bus_rd_addr = 4'd1; #1;
        check("R2", "reg1", int'(bus_rd_data), 16'h5D76);

        // R3: mask 15 blocks everything
        periph_req = '1;
        tick();
        check("R3", "blocked by mask 15", int'(irq_req), 0);
        periph_req = '0;
        set_mask(0);
        check("R9", "mask loaded", int'(mask_lvl), 0);

        // R5/R6: single source one edge later
        periph_req = 10'b1;
        tick();
        check("R5", "src0 req", int'(irq_req), 1);
        check("R6", "src0 vec", int'(irq_vec), VB);

        // R4: highest level wins (src6 level 13)
        periph_req = '1;
        tick();
        check("R4", "winner src", int'(irq_src), 6);
        check("R4", "winner lvl", int'(irq_lvl), 13);

        // R8: acceptance
        irq_ack = 1'b1;
        tick();
        check("R8", "req after ack", int'(irq_req), 0);
        check("R8", "mask after ack", int'(mask_lvl), 13);
        tick();
        check("R3", "equal level not above mask", int'(irq_req), 0);

        // R4: tie among peripherals, lowest index
        periph_req = '0;
        bus_write(0, 16'h9999);
        set_mask(0);
        periph_req = 10'b1100;
        tick();
        check("R4", "tie lowest index", int'(irq_src), 2);

        // R3: level 0 never forwarded
        periph_req = '0;
        bus_write(1, 16'h5D70);
        periph_req = 10'b1 << 4;
        tick();
        tick();
        check("R3", "level 0 source", int'(irq_req), 0);
        periph_req = '0;
        tick();

        // R7/R4: both debug edges together, breakpoint first
        brk_in = 1'b1; sdbg_in = 1'b1;
        periph_req = 10'b1 << 6;
        tick();
        check("R7", "brk src", int'(irq_src), BRK);
        check("R7", "brk lvl", int'(irq_lvl), 15);
        check("R6", "brk vec", int'(irq_vec), BVEC);
        sdbg_in = 1'b0;
        irq_ack = 1'b1;
        tick();
        check("R8", "mask after brk", int'(mask_lvl), 15);
        periph_req = '0;
        set_mask(0);
        tick();
        check("R7", "sdbg held pending", int'(irq_src), DBG);
        check("R6", "sdbg vec", int'(irq_vec), DVEC);
        irq_ack = 1'b1;
        tick();
        set_mask(0);
        tick();
        check("R7", "held high no re-raise", int'(irq_req), 0);
        brk_in = 1'b0;

        // R8: ack while idle ignored
        irq_ack = 1'b1;
        tick();
        check("R8", "idle ack ignored", int'(mask_lvl), 0);

        // R9: acceptance wins over direct mask load
        periph_req = 10'b1;
        tick();
        irq_ack = 1'b1; mask_wr_en = 1'b1; mask_wr_lvl = 4'd3;
        tick();
        check("R9", "ack over mask write", int'(mask_lvl), 9);
        periph_req = '0;

        // mixed random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            periph_req  = N'($urandom);
            if ($urandom_range(0, 7) == 0) brk_in  = ~brk_in;
            if ($urandom_range(0, 7) == 0) sdbg_in = ~sdbg_in;
            irq_ack     = ($urandom_range(0, 2) == 0);
            mask_wr_en  = ($urandom_range(0, 7) == 0);
            mask_wr_lvl = 4'($urandom_range(0, 15));
            bus_wr_en   = ($urandom_range(0, 15) == 0);
            bus_wr_addr = 4'($urandom_range(0, 4));
            bus_wr_data = 16'($urandom);
            bus_rd_addr = 4'($urandom_range(0, 4));
            tick();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule